// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block sequences power-down and wake-up for a small microcontroller core. When the instruction decoder strobes a sleep request, the block first checks whether any interrupt source already has both its flag and its enable bit set. If one does, the request completes as a no-op. If none does, the block performs the sleep. It pulses a watchdog clear, clears the power-down status bit, sets the time-out status bit, and drops the oscillator enable and the core run signal, which holds all core state, I/O included.

While asleep, three events end the sleep. An external reset has the highest priority, a watchdog time-out counts only when the watchdog is enabled, and an enabled pending interrupt has the lowest priority. The global interrupt enable plays no part in deciding whether to wake. On a wake the oscillator enable returns at once, and the run signal is released after a fixed start-up delay. A one-cycle resume strobe then tells the core how to continue: run the pre-fetched next instruction, run it and then branch to the interrupt vector, or restart from reset. A watchdog wake also clears the time-out bit, so software can tell the wake causes apart from the status bits.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, pd_o=1, to_o=1, osc_en_o=1, run_o=1, wdt_clr_o=0, resume_o=0 and resume_kind_o=0.
- R2: A sleep_i strobe while running, with no source having both flag and enable set, leads in the next cycle to osc_en_o=0, run_o=0, pd_o=0, to_o=1, and wdt_clr_o high for exactly that one cycle. pd_o then stays 0 until power-on reset.
- R3: A sleep_i strobe while running, with any source having both flag and enable set in that cycle, changes no output and produces no wdt_clr_o pulse.
- R4: A source whose flag is set but whose enable bit is clear neither wakes the block nor turns a sleep into a no-op.
- R5: While asleep, an enabled pending interrupt wakes the block whatever the value of gie_i. The resume kind is 0 (next instruction) when gie_i=0 and 1 (next instruction, then vector) when gie_i=1. gie_i is sampled in the wake cycle.
- R6: While asleep, wdt_to_i wakes the block only when wdt_en_i=1. Such a wake clears to_o and gives resume kind 0. With wdt_en_i=0 the pulse is ignored.
- R7: While asleep or warming up, ext_rst_i gives resume kind 2 (restart) and leaves pd_o and to_o unchanged.
- R8: Wake causes that arrive in the same cycle are ranked: external reset first, then watchdog time-out, then interrupt. A lower-ranked cause has no effect on the status bits or the kind.
- R9: osc_en_o rises in the cycle after the wake event. run_o and a one-cycle resume_o rise together exactly STARTUP_CYC cycles after osc_en_o rises.
- R10: An interrupt that becomes pending in the cycle after a performed sleep does not cancel the sleep. pd_o is cleared, and the block wakes at the next edge.
- R11: While running, wdt_to_i and ext_rst_i leave every output of this block unchanged. Device reset from these inputs is handled outside the block.
- R12: sleep_i has no effect while asleep or warming up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_i | input | 1 | One-cycle sleep strobe from the decoder |
| int_flag_i | input | N_SRC | Per-source interrupt flags |
| int_en_i | input | N_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| ext_rst_i | input | 1 | External reset request |
| osc_en_o | output | 1 | Oscillator driver enable |
| run_o | output | 1 | Core may advance |
| wdt_clr_o | output | 1 | Watchdog and postscaler clear pulse |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| resume_o | output | 1 | One-cycle strobe when the core restarts after a wake |
| resume_kind_o | output | 2 | 0 next instruction, 1 next then vector, 2 restart |

## Verification
The hardest situations to reach are the narrow races around the sleep strobe. One is an interrupt that becomes pending exactly one cycle after a performed sleep, which must not cancel it. The other is several wake causes landing in the same sleeping cycle. The stimulus drives inputs on the falling edge, so a flag can be raised in the cycle directly after the strobe, and it fires external reset, watchdog time-out and an enabled interrupt together. A behavioural reference model, compared on every clock, confirms that status bits, resume kind and start-up timing follow the ranking.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_ASLEEP = 2'd1,
      ST_WARM   = 2'd2
   } pwr_state_e;

   typedef enum logic [1:0] {
      RES_NEXT    = 2'd0,
      RES_VECTOR  = 2'd1,
      RES_RESTART = 2'd2
   } resume_e;
endpackage

// File: rtl/wake_merge.sv
module wake_merge #(
   parameter int unsigned N_SRC = 8
) (
   input  logic [N_SRC-1:0] flag_i,
   input  logic [N_SRC-1:0] en_i,
   output logic             req_o
);
   logic [N_SRC-1:0] hit;

   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("wake_merge: N_SRC must be at least 1");
      end
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         assign hit[i] = flag_i[i] & en_i[i];
      end
   endgenerate

   assign req_o = |hit;
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic done_o
);
   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("startup_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!active_i)  cnt <= '0;
      else if (!done_o)    cnt <= cnt + 1'b1;
   end

   assign done_o = active_i && (cnt == LAST);

   // R9: the count never passes its terminal value
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (cnt <= LAST));
endmodule

// File: rtl/pwr_status.sv
module pwr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_do_i,
   input  logic wdt_wake_i,
   output logic pd_o,
   output logic to_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_o <= 1'b1;
         to_o <= 1'b1;
      end else if (sleep_do_i) begin
         pd_o <= 1'b0;
         to_o <= 1'b1;
      end else if (wdt_wake_i) begin
         to_o <= 1'b0;
      end
   end

   // R2: once cleared, power-down stays clear until power-on reset
   p_pd_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_o |=> !pd_o);

   // R6: time-out only falls through a watchdog wake
   p_to_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_o) |-> $past(wdt_wake_i));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import pwr_pkg::*;
#(
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned STARTUP_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic [N_SRC-1:0] int_flag_i,
   input  logic [N_SRC-1:0] int_en_i,
   input  logic             gie_i,
   input  logic             wdt_en_i,
   input  logic             wdt_to_i,
   input  logic             ext_rst_i,
   output logic             osc_en_o,
   output logic             run_o,
   output logic             wdt_clr_o,
   output logic             pd_o,
   output logic             to_o,
   output logic             resume_o,
   output logic [1:0]       resume_kind_o
);
   pwr_state_e state;
   resume_e    kind_q;
   logic       osc_q, run_q, clr_q, res_q;
   logic       wake_req, warm_done;
   logic       sleep_do, ext_wake, wdt_wake, int_wake, any_wake;

   wake_merge #(.N_SRC(N_SRC)) i_merge (
      .flag_i (int_flag_i),
      .en_i   (int_en_i),
      .req_o  (wake_req)
   );

   startup_timer #(.CYCLES(STARTUP_CYC)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (state == ST_WARM),
      .done_o   (warm_done)
   );

   assign sleep_do = (state == ST_RUN) && sleep_i && !wake_req;
   assign ext_wake = (state == ST_ASLEEP) && ext_rst_i;
   assign wdt_wake = (state == ST_ASLEEP) && !ext_rst_i && wdt_to_i && wdt_en_i;
   assign int_wake = (state == ST_ASLEEP) && wake_req;
   assign any_wake = ext_wake || wdt_wake || int_wake;

   pwr_status i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_do_i (sleep_do),
      .wdt_wake_i (wdt_wake),
      .pd_o       (pd_o),
      .to_o       (to_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         kind_q <= RES_NEXT;
         osc_q  <= 1'b1;
         run_q  <= 1'b1;
         clr_q  <= 1'b0;
         res_q  <= 1'b0;
      end else begin
         clr_q <= sleep_do;
         res_q <= 1'b0;
         case (state)
            ST_RUN: begin
               if (sleep_do) begin
                  state <= ST_ASLEEP;
                  osc_q <= 1'b0;
                  run_q <= 1'b0;
               end
            end
            ST_ASLEEP: begin
               if (any_wake) begin
                  state <= ST_WARM;
                  osc_q <= 1'b1;
                  if (ext_wake)      kind_q <= RES_RESTART;
                  else if (wdt_wake) kind_q <= RES_NEXT;
                  else               kind_q <= gie_i ? RES_VECTOR : RES_NEXT;
               end
            end
            ST_WARM: begin
               if (ext_rst_i) kind_q <= RES_RESTART;
               if (warm_done) begin
                  state <= ST_RUN;
                  run_q <= 1'b1;
                  res_q <= 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assign osc_en_o      = osc_q;
   assign run_o         = run_q;
   assign wdt_clr_o     = clr_q;
   assign resume_o      = res_q;
   assign resume_kind_o = kind_q;

   // R3: a sleep with an enabled pending source leaves the core running
   p_nop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_i && wake_req) |=> (run_o && osc_en_o && !wdt_clr_o));

   // R2: a performed sleep stops the clock and clears the watchdog once
   p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_do |=> (!osc_en_o && !run_o && !pd_o && to_o && wdt_clr_o));

   p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr_o |=> !wdt_clr_o);

   // R9: wake restarts the oscillator before the core
   p_wake_osc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_wake |=> (osc_en_o && !run_o));

   p_resume_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> (run_o && $past(!run_o)));

   p_run_needs_osc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> osc_en_o);

   // R7: external reset wake always reports a restart
   p_ext_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wake |=> (resume_kind_o == 2'd2));
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
   localparam int NS = 4;
   localparam int SU = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_i = 1'b0;
   logic [NS-1:0] flag = '0;
   logic [NS-1:0] en = '0;
   logic gie = 1'b0, wen = 1'b0, wto = 1'b0, ext = 1'b0;
   logic osc, run, clr, pd, to, res;
   logic [1:0] kind;

   int checks = 0;
   int fails = 0;
   bit started = 1'b0;
   bit done = 1'b0;
   string phase = "R1";

   // reference model state
   int m_st = 0, m_cnt = 0, m_kind = 0;
   bit m_pd = 1, m_to = 1, m_osc = 1, m_run = 1, m_clr = 0, m_res = 0;
   bit hit;

   always #2 clk = ~clk;

   sleep_wake_ctrl #(.N_SRC(NS), .STARTUP_CYC(SU)) i_sleep_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .int_flag_i(flag), .int_en_i(en), .gie_i(gie),
      .wdt_en_i(wen), .wdt_to_i(wto), .ext_rst_i(ext),
      .osc_en_o(osc), .run_o(run), .wdt_clr_o(clr),
      .pd_o(pd), .to_o(to), .resume_o(res), .resume_kind_o(kind));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_kind = 0;
         m_pd = 1; m_to = 1; m_osc = 1; m_run = 1; m_clr = 0; m_res = 0;
      end else begin
         hit = |(flag & en);
         m_clr = 0;
         m_res = 0;
         if (m_st == 0) begin
            if (sleep_i && !hit) begin
               m_st = 1; m_pd = 0; m_to = 1; m_osc = 0; m_run = 0; m_clr = 1;
            end
         end else if (m_st == 1) begin
            if (ext || (wto && wen) || hit) begin
               if (ext) m_kind = 2;
               else if (wto && wen) begin m_kind = 0; m_to = 0; end
               else m_kind = gie ? 1 : 0;
               m_st = 2; m_osc = 1; m_cnt = 0;
            end
         end else begin
            if (ext) m_kind = 2;
            if (m_cnt == SU - 1) begin
               m_st = 0; m_run = 1; m_res = 1;
            end else m_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if ({osc, run, clr, pd, to, res, kind} !==
             {m_osc, m_run, m_clr, m_pd, m_to, m_res, 2'(m_kind)}) begin
            fails++;
            $display("FAIL %s: osc/run/clr/pd/to/res/kind actual %b%b%b%b%b%b %0d expected %b%b%b%b%b%b %0d",
                     phase, osc, run, clr, pd, to, res, kind,
                     m_osc, m_run, m_clr, m_pd, m_to, m_res, m_kind);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_sleep();
      @(negedge clk) sleep_i = 1'b1;
      @(negedge clk) sleep_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      started = 1'b1;
      phase = "R1";
      step(3);
      // R2: plain sleep
      phase = "R2"; en = 4'hF;
      do_sleep(); step(4);
      // R5 wake with gie clear
      phase = "R5"; flag[1] = 1'b1; step(1); flag[1] = 1'b0; step(SU + 3);
      // R12 strobe while asleep, R4 flag without enable
      do_sleep(); phase = "R12"; step(1); do_sleep(); step(2);
      phase = "R4"; en = 4'h0; flag[2] = 1'b1; step(4);
      // R5 wake with gie set
      phase = "R5"; gie = 1'b1; en[2] = 1'b1; step(1); flag[2] = 1'b0;
      phase = "R12"; do_sleep(); step(SU + 2); gie = 1'b0;
      // R3 no-op sleep
      phase = "R3"; flag[0] = 1'b1; en = 4'h1; do_sleep(); step(3);
      flag = '0; en = 4'hF;
      // R4 at entry, then R6
      phase = "R4"; en = 4'h7; flag[3] = 1'b1; do_sleep(); step(3);
      phase = "R6"; wen = 1'b0; wto = 1'b1; step(1); wto = 1'b0; step(3);
      wen = 1'b1; wto = 1'b1; step(1); wto = 1'b0; step(SU + 3);
      flag = '0; en = 4'hF;
      // R7 external reset wake, upgrade during warm-up
      phase = "R7"; do_sleep(); step(2); ext = 1'b1; step(1); ext = 1'b0; step(SU + 3);
      do_sleep(); step(2); gie = 1'b1; flag[0] = 1'b1; step(1); flag[0] = 1'b0;
      step(1); ext = 1'b1; step(1); ext = 1'b0; step(SU + 2); gie = 1'b0;
      // R8 simultaneous causes
      phase = "R8"; do_sleep(); step(2);
      ext = 1'b1; wto = 1'b1; flag[1] = 1'b1; step(1);
      ext = 1'b0; wto = 1'b0; flag[1] = 1'b0; step(SU + 3);
      do_sleep(); step(2); gie = 1'b1; wto = 1'b1; flag[1] = 1'b1; step(1);
      wto = 1'b0; flag[1] = 1'b0; gie = 1'b0; step(SU + 3);
      // R10 interrupt right after a performed sleep
      phase = "R10";
      @(negedge clk) sleep_i = 1'b1;
      @(negedge clk) begin sleep_i = 1'b0; flag[2] = 1'b1; end
      step(1); flag[2] = 1'b0; step(SU + 3);
      // R11 running: time-out and external reset ignored
      phase = "R11"; wto = 1'b1; ext = 1'b1; step(2); wto = 1'b0; ext = 1'b0; step(3);
      // R9 start-up timing exercised across all wakes above; one more interrupt wake
      phase = "R9"; do_sleep(); step(1); flag[3] = 1'b1; step(1); flag[3] = 1'b0; step(SU + 3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule